// File: doc/BRIEF.md
# Processor Control Sequencer

This block is the control half of a small single-issue processor. Each cycle it takes the class of the current instruction, already decoded into one-hot style flags, plus the acknowledge lines of the input and output ports. From these it drives the datapath's steering and enable lines: the program-counter stall select, the data-memory write enable and access request, the register-file write enable and write-source select, the ALU opcode, and the input and output port requests.

Most instructions complete in the run state. Port reads and port writes enter a wait state that holds the program counter until the port acknowledges. A load takes one extra memory-read cycle, in which the returned word is written back. A halt parks the machine until reset. The state register, the next-state logic and the output logic are three separate pieces.

Top module: `proc_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, the block is in the run state: stall_o=0, no request line is high, no write enable is high unless the current instruction asks for one.
- R2: In the run state the instruction class is decoded with priority halt > read > write > load > store > other when several flags are set at once.
- R3: A read instruction in the run state enters a port-read wait state. That state holds stall_o=1 and in_req_o=1 for as long as in_ack_i is low. The run state resumes on the cycle after in_ack_i is seen high.
- R4: In the port-read state, rf_we_o equals in_ack_i and reg_sel_o is 1, meaning the input port.
- R5: A write instruction in the run state enters a port-write wait state. That state holds stall_o=1 and out_req_o=1, and returns to run on the cycle after out_ack_i is seen high. It never writes the register file.
- R6: A load instruction in the run state raises mem_req_o. The next cycle is a single memory-read cycle with stall_o=1, mem_req_o=1, rf_we_o=1 and reg_sel_o=2 (memory). Run resumes on the cycle after that, whatever the inputs are.
- R7: A halt instruction in the run state enters the halt state. Halt is left only by reset; there stall_o=1 and every enable and request is 0.
- R8: In the run state, dmem_we_o and mem_req_o are 1 for a store that no higher class overrides. rf_we_o equals alu_wb_i for an "other" instruction, with reg_sel_o=0 (ALU). op_code_o copies alu_op_i in run and is 0 in every other state.
- R9: in_req_o is 1 only in the port-read state and out_req_o only in the port-write state. Acknowledges arriving in any other state change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| is_halt_i | input | 1 | Current instruction is a halt |
| is_read_i | input | 1 | Current instruction reads the input port |
| is_write_i | input | 1 | Current instruction writes the output port |
| is_load_i | input | 1 | Current instruction loads from data memory |
| is_store_i | input | 1 | Current instruction stores to data memory |
| alu_wb_i | input | 1 | An "other" instruction writes its ALU result back |
| alu_op_i | input | OP_W | Decoded ALU operation |
| in_ack_i | input | 1 | Input port acknowledge |
| out_ack_i | input | 1 | Output port acknowledge |
| stall_o | output | 1 | Program counter hold select |
| dmem_we_o | output | 1 | Data memory write enable |
| mem_req_o | output | 1 | Data memory access request |
| rf_we_o | output | 1 | Register file write enable |
| reg_sel_o | output | 2 | Write-back source: 0 ALU, 1 input port, 2 memory |
| op_code_o | output | OP_W | ALU opcode to the datapath |
| in_req_o | output | 1 | Input port request |
| out_req_o | output | 1 | Output port request |

## Verification
The hardest cases to reach are long acknowledge waits that come right after another multi-cycle instruction, and instructions with several class flags set at once. The stimulus generator sets extra flags on top of the main class and keeps each acknowledge low most of the time, so wait states often last many cycles. Halt traps the machine for good, so the stimulus gives halt a low weight and applies a reset once the machine has sat in halt for a few cycles. Random mid-run resets also land on the wait states.

// File: rtl/proc_ctrl_pkg.sv
package proc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_PRD   = 3'd2,
    ST_PWR   = 3'd3,
    ST_MRD   = 3'd4
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SRC_ALU  = 2'd0,
    SRC_PORT = 2'd1,
    SRC_MEM  = 2'd2
  } wb_src_e;

  typedef struct packed {
    logic halt;
    logic read;
    logic write;
    logic load;
    logic store;
    logic alu_wb;
  } insn_cls_t;

endpackage

// File: rtl/ctrl_state_reg.sv
module ctrl_state_reg
  import proc_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ctrl_state_e state_d_i,
  output ctrl_state_e state_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q_o <= ST_RUN;
    else         state_q_o <= state_d_i;
  end

endmodule

// File: rtl/ctrl_next_state.sv
module ctrl_next_state
  import proc_ctrl_pkg::*;
(
  input  ctrl_state_e state_i,
  input  insn_cls_t   cls_i,
  input  logic        in_ack_i,
  input  logic        out_ack_i,
  output ctrl_state_e state_d_o
);

  always_comb begin
    state_d_o = state_i;
    unique case (state_i)
      ST_RUN: begin
        if      (cls_i.halt)  state_d_o = ST_HALT;
        else if (cls_i.read)  state_d_o = ST_PRD;
        else if (cls_i.write) state_d_o = ST_PWR;
        else if (cls_i.load)  state_d_o = ST_MRD;
      end
      ST_PRD:  if (in_ack_i)  state_d_o = ST_RUN;
      ST_PWR:  if (out_ack_i) state_d_o = ST_RUN;
      ST_MRD:  state_d_o = ST_RUN;
      ST_HALT: state_d_o = ST_HALT;
      default: state_d_o = ST_RUN;
    endcase
  end

endmodule

// File: rtl/ctrl_outputs.sv
module ctrl_outputs
  import proc_ctrl_pkg::*;
#(
  parameter int unsigned OP_W = 4
) (
  input  ctrl_state_e     state_i,
  input  insn_cls_t       cls_i,
  input  logic [OP_W-1:0] alu_op_i,
  input  logic            in_ack_i,
  output logic            stall_o,
  output logic            dmem_we_o,
  output logic            mem_req_o,
  output logic            rf_we_o,
  output wb_src_e         reg_sel_o,
  output logic [OP_W-1:0] op_code_o,
  output logic            in_req_o,
  output logic            out_req_o
);

  localparam logic [OP_W-1:0] OP_IDLE = '0;

  logic run_other;
  logic run_store;

  // lower classes only act when nothing above them is set
  assign run_store = cls_i.store & ~(cls_i.halt | cls_i.read | cls_i.write | cls_i.load);
  assign run_other = ~(cls_i.halt | cls_i.read | cls_i.write | cls_i.load | cls_i.store);

  always_comb begin
    stall_o   = 1'b0;
    dmem_we_o = 1'b0;
    mem_req_o = 1'b0;
    rf_we_o   = 1'b0;
    reg_sel_o = SRC_ALU;
    op_code_o = OP_IDLE;
    in_req_o  = 1'b0;
    out_req_o = 1'b0;
    unique case (state_i)
      ST_RUN: begin
        op_code_o = alu_op_i;
        if (run_store) begin
          dmem_we_o = 1'b1;
          mem_req_o = 1'b1;
        end else if (cls_i.load && !(cls_i.halt || cls_i.read || cls_i.write)) begin
          mem_req_o = 1'b1;
        end else if (run_other) begin
          rf_we_o = cls_i.alu_wb;
        end
      end
      ST_PRD: begin
        stall_o   = 1'b1;
        in_req_o  = 1'b1;
        reg_sel_o = SRC_PORT;
        rf_we_o   = in_ack_i;
      end
      ST_PWR: begin
        stall_o   = 1'b1;
        out_req_o = 1'b1;
      end
      ST_MRD: begin
        stall_o   = 1'b1;
        mem_req_o = 1'b1;
        rf_we_o   = 1'b1;
        reg_sel_o = SRC_MEM;
      end
      ST_HALT: stall_o = 1'b1;
      default: stall_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/proc_ctrl.sv
module proc_ctrl
  import proc_ctrl_pkg::*;
#(
  parameter int unsigned OP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            is_halt_i,
  input  logic            is_read_i,
  input  logic            is_write_i,
  input  logic            is_load_i,
  input  logic            is_store_i,
  input  logic            alu_wb_i,
  input  logic [OP_W-1:0] alu_op_i,
  input  logic            in_ack_i,
  input  logic            out_ack_i,
  output logic            stall_o,
  output logic            dmem_we_o,
  output logic            mem_req_o,
  output logic            rf_we_o,
  output logic [1:0]      reg_sel_o,
  output logic [OP_W-1:0] op_code_o,
  output logic            in_req_o,
  output logic            out_req_o
);

  ctrl_state_e state_q, state_d;
  insn_cls_t   cls;
  wb_src_e     reg_sel;

  assign cls = '{halt: is_halt_i, read: is_read_i, write: is_write_i,
                 load: is_load_i, store: is_store_i, alu_wb: alu_wb_i};

  ctrl_state_reg u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .state_q_o (state_q)
  );

  ctrl_next_state u_next (
    .state_i   (state_q),
    .cls_i     (cls),
    .in_ack_i  (in_ack_i),
    .out_ack_i (out_ack_i),
    .state_d_o (state_d)
  );

  ctrl_outputs #(.OP_W(OP_W)) u_out (
    .state_i   (state_q),
    .cls_i     (cls),
    .alu_op_i  (alu_op_i),
    .in_ack_i  (in_ack_i),
    .stall_o   (stall_o),
    .dmem_we_o (dmem_we_o),
    .mem_req_o (mem_req_o),
    .rf_we_o   (rf_we_o),
    .reg_sel_o (reg_sel),
    .op_code_o (op_code_o),
    .in_req_o  (in_req_o),
    .out_req_o (out_req_o)
  );

  assign reg_sel_o = reg_sel;

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> state_q == ST_HALT && stall_o && !rf_we_o && !dmem_we_o);

  assert_mrd_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MRD |=> state_q == ST_RUN);

  assert_prd_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o && !in_ack_i |=> in_req_o && stall_o);

  assert_pwr_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_req_o && !out_ack_i |=> out_req_o && stall_o);

  assert_prd_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o && in_ack_i |=> !in_req_o && !stall_o);

  assert_port_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o && rf_we_o |-> in_ack_i && reg_sel_o == 2'd1);

  assert_req_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_req_o, out_req_o, dmem_we_o}));

endmodule

// File: tb/sim_proc_ctrl.sv
module sim_proc_ctrl;

  localparam int OP_W   = 4;
  localparam int NCYC   = 4000;
  localparam int S_RUN = 0, S_HALT = 1, S_PRD = 2, S_PWR = 3, S_MRD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic is_halt, is_read, is_write, is_load, is_store, alu_wb, in_ack, out_ack;
  logic [OP_W-1:0] alu_op;
  logic stall, dmem_we, mem_req, rf_we, in_req, out_req;
  logic [1:0] reg_sel;
  logic [OP_W-1:0] op_code;

  int n_chk = 0, n_fail = 0;
  int mstate = S_RUN;
  bit done = 0;

  always #10 clk = ~clk;

  proc_ctrl #(.OP_W(OP_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .is_halt_i(is_halt), .is_read_i(is_read), .is_write_i(is_write),
    .is_load_i(is_load), .is_store_i(is_store), .alu_wb_i(alu_wb),
    .alu_op_i(alu_op), .in_ack_i(in_ack), .out_ack_i(out_ack),
    .stall_o(stall), .dmem_we_o(dmem_we), .mem_req_o(mem_req), .rf_we_o(rf_we),
    .reg_sel_o(reg_sel), .op_code_o(op_code), .in_req_o(in_req), .out_req_o(out_req)
  );

  // expected outputs packed: stall,dmem_we,mem_req,rf_we,reg_sel[1:0],in_req,out_req,op_code
  function automatic logic [8+OP_W-1:0] expect_out(int st);
    logic s = 0, dw = 0, mr = 0, rw = 0, ir = 0, orq = 0;
    logic [1:0] rs = 0;
    logic [OP_W-1:0] op = 0;
    case (st)
      S_RUN: begin
        op = alu_op;
        if (is_halt || is_read || is_write) ;
        else if (is_load) mr = 1;
        else if (is_store) begin dw = 1; mr = 1; end
        else rw = alu_wb;
      end
      S_PRD: begin s = 1; ir = 1; rs = 1; rw = in_ack; end
      S_PWR: begin s = 1; orq = 1; end
      S_MRD: begin s = 1; mr = 1; rw = 1; rs = 2; end
      default: s = 1;
    endcase
    return {s, dw, mr, rw, rs, ir, orq, op};
  endfunction

  function automatic int next_of(int st);
    case (st)
      S_RUN:  return is_halt ? S_HALT : is_read ? S_PRD : is_write ? S_PWR :
                     is_load ? S_MRD : S_RUN;
      S_PRD:  return in_ack ? S_RUN : S_PRD;
      S_PWR:  return out_ack ? S_RUN : S_PWR;
      S_MRD:  return S_RUN;
      default: return S_HALT;
    endcase
  endfunction

  task automatic check(string tag);
    logic [8+OP_W-1:0] exp_v, act_v;
    exp_v = expect_out(mstate);
    act_v = {stall, dmem_we, mem_req, rf_we, reg_sel, in_req, out_req, op_code};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s state=%0d actual=%b expected=%b (stall,dwe,mreq,rfwe,sel,ireq,oreq,op)",
               tag, mstate, act_v, exp_v);
    end
  endtask

  function automatic string tag_of(int st);
    case (st)
      S_RUN:  return "R2 R8";
      S_PRD:  return "R3 R4 R9";
      S_PWR:  return "R5 R9";
      S_MRD:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive_rand();
    int p = $urandom_range(0, 99);
    is_halt  = (p < 3);
    is_read  = (p >= 3  && p < 17);
    is_write = (p >= 17 && p < 31);
    is_load  = (p >= 31 && p < 45);
    is_store = (p >= 45 && p < 60);
    // extra flags to exercise priority (R2)
    if ($urandom_range(0, 7) == 0) is_store = 1;
    if ($urandom_range(0, 9) == 0) is_load  = 1;
    if ($urandom_range(0, 11) == 0) is_write = 1;
    alu_wb  = $urandom_range(0, 1);
    alu_op  = OP_W'($urandom_range(0, 15));
    in_ack  = ($urandom_range(0, 9) < 3);
    out_ack = ($urandom_range(0, 9) < 3);
  endtask

  initial begin
    int halt_cnt = 0;
    void'($urandom(7));
    drive_rand();
    // R1: reset state
    #5 mstate = S_RUN;
    check("R1");
    @(negedge clk); drive_rand(); #2 check("R1");
    @(negedge clk); rst_ni = 1'b1; drive_rand(); #2 check("R1");
    @(posedge clk); mstate = next_of(mstate);
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      drive_rand();
      if (mstate == S_HALT) halt_cnt++; else halt_cnt = 0;
      if (halt_cnt > 6 || $urandom_range(0, 199) == 0) begin
        rst_ni = 1'b0;
        mstate = S_RUN;
        halt_cnt = 0;
        #2 check("R1");
        @(negedge clk); rst_ni = 1'b1; drive_rand(); #2 check("R1");
      end else begin
        #2 check(tag_of(mstate));
      end
      @(posedge clk);
      mstate = next_of(mstate);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule